// File: doc/BRIEF.md
# Set-Dueling Spill/Receive Role Selector

This block decides, for each of four private caches, whether an evicted line should be pushed to a peer cache (spill) or whether the cache should accept lines pushed by peers (receive). Each cache gives up a few of its sets to testing. One small group of sets always spills, another always receives, and the rest follow whichever policy has been producing fewer misses. Group membership comes from a fixed arithmetic hash of the set index and the cache number, so no membership table is stored.

Each cache has its own saturating selection counter. A miss counts toward a cache's counter whenever it lands in one of that cache's test sets, whichever cache reported the miss, so the counter follows system-wide misses rather than local ones. Every cache reports at most one miss per cycle on its own port, and all ports update the counters in the same cycle. A combinational query port returns the effective role bit and the set's class for any (cache, set) pair. A per-cache learned-policy vector is also driven out.

Top module: `spill_receive_selector`

## Requirements
- R1: Set s is in the always-spill group of cache c exactly when (s[4:0] − s[9:5]) mod 32 equals c. The query class output then reads 1. Each cache has 32 such sets.
- R2: Set s is in the always-receive group of cache c exactly when (s[4:0] − s[9:5]) mod 32 equals c+4. The query class output then reads 2. Each cache has 32 such sets.
- R3: No set belongs to more than one test group across all caches and both kinds. All other (cache, set) pairs are followers, and the class output reads 0 for them.
- R4: A valid miss from any port whose set is an always-spill set of cache c lowers counter c by one.
- R5: A valid miss from any port whose set is an always-receive set of cache c raises counter c by one.
- R6: Misses in follower sets, and ports with the valid bit low, leave every counter unchanged.
- R7: Each 10-bit counter saturates at 1023 going up and at 0 going down.
- R8: The asynchronous active-low reset sets every counter to 512, so every learned policy bit reads 1 (spill).
- R9: For a follower set, the role output equals the most significant bit of the queried cache's counter: 1 means spill and 0 means receive.
- R10: The role output is 1 for an always-spill set and 0 for an always-receive set, whatever the counter holds.
- R11: Several misses in one cycle are all applied. The counter moves by (receive hits − spill hits) in a single step, and the result is clamped.
- R12: The counters are registered. A miss presented before a rising edge shows in the policy and role outputs after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 4 | One miss strobe per cache port |
| miss_set_i | input | 40 | Set index of each port's miss, port p at bits [10p+9:10p] |
| query_cache_i | input | 2 | Cache number of the query |
| query_set_i | input | 10 | Set index of the query |
| role_o | output | 1 | Effective role for the query: 1 spill, 0 receive |
| class_o | output | 2 | Query set class: 0 follower, 1 always-spill, 2 always-receive |
| policy_o | output | 4 | Learned policy per cache (counter MSB) |

## Verification
The hardest conditions to reach from the ports are a counter held at either saturation limit and then reversed, and the exact edge on which the learned bit flips. Both need hundreds of test-set misses aimed at a single cache. The stimulus produces them by building set indices from the hash: it picks a random upper field and derives the matching lower field. With all four ports doing this, a counter is driven to 1023 and then down to 0, and the learned bit must flip on the 512th net decrement. The bench also drives cycles in which a spill hit and a receive hit for the same cache cancel. A full sweep of every (cache, set) pair counts the group sizes and confirms that no two groups overlap.

// File: rtl/spill_dueling_pkg.sv
package spill_dueling_pkg;
  localparam int unsigned DEF_NUM_CACHES = 4;
  localparam int unsigned DEF_SET_W      = 10;
  localparam int unsigned DEF_LO_W       = 5;
  localparam int unsigned DEF_CNT_W      = 10;

  typedef enum logic [1:0] {
    CLS_FOLLOW = 2'd0,
    CLS_SPILL  = 2'd1,
    CLS_RECV   = 2'd2
  } set_class_e;
endpackage

// File: rtl/sdm_classifier.sv
module sdm_classifier #(
  parameter int unsigned SET_W      = 10,
  parameter int unsigned LO_W       = 5,
  parameter int unsigned NUM_CACHES = 4,
  parameter int unsigned CACHE_ID   = 0
) (
  input  logic [SET_W-1:0] set_i,
  output logic             spill_o,
  output logic             recv_o
);
  localparam logic [LO_W-1:0] SPILL_TAG = LO_W'(CACHE_ID);
  localparam logic [LO_W-1:0] RECV_TAG  = LO_W'(CACHE_ID + NUM_CACHES);

  logic [LO_W-1:0] lo_bits, hi_bits, tag;

  assign lo_bits = set_i[LO_W-1:0];
  assign hi_bits = LO_W'(set_i[SET_W-1:LO_W]);
  // modular difference selects one lower value per upper value
  assign tag     = lo_bits - hi_bits;

  assign spill_o = (tag == SPILL_TAG);
  assign recv_o  = (tag == RECV_TAG);
endmodule

// File: rtl/psel_counter.sv
module psel_counter #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned EV_W  = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [EV_W-1:0] up_i,
  input  logic [EV_W-1:0] dn_i,
  output logic            msb_o
);
  localparam int unsigned EXT_W = CNT_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MID = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXT_W-1:0] sum;

  always_comb begin
    sum = EXT_W'(cnt_q) + EXT_W'(up_i) - EXT_W'(dn_i);
    if (sum[EXT_W-1])                 cnt_d = '0;
    else if (sum > EXT_W'(CNT_MAX))   cnt_d = CNT_MAX;
    else                              cnt_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_MID;
    else         cnt_q <= cnt_d;
  end

  assign msb_o = cnt_q[CNT_W-1];

  a_r7_hold_at_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && up_i >= dn_i) |=> (cnt_q == CNT_MAX));
  a_r7_hold_at_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && dn_i >= up_i) |=> (cnt_q == '0));
  a_r6_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i == dn_i) |=> $stable(cnt_q));
  a_r5_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i > dn_i && cnt_q != CNT_MAX) |=> (cnt_q > $past(cnt_q)));
  a_r4_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_i > up_i && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/role_select.sv
module role_select
  import spill_dueling_pkg::*;
#(
  parameter int unsigned NUM_CACHES = 4,
  parameter int unsigned ID_W       = 2
) (
  input  logic [ID_W-1:0]       query_id_i,
  input  logic [NUM_CACHES-1:0] spill_i,
  input  logic [NUM_CACHES-1:0] recv_i,
  input  logic [NUM_CACHES-1:0] policy_i,
  output logic                  role_o,
  output set_class_e            class_o
);
  always_comb begin
    if (spill_i[query_id_i]) begin
      class_o = CLS_SPILL;
      role_o  = 1'b1;
    end else if (recv_i[query_id_i]) begin
      class_o = CLS_RECV;
      role_o  = 1'b0;
    end else begin
      class_o = CLS_FOLLOW;
      role_o  = policy_i[query_id_i];
    end
  end
endmodule

// File: rtl/spill_receive_selector.sv
module spill_receive_selector
  import spill_dueling_pkg::*;
#(
  parameter int unsigned NUM_CACHES = DEF_NUM_CACHES,
  parameter int unsigned SET_W      = DEF_SET_W,
  parameter int unsigned LO_W       = DEF_LO_W,
  parameter int unsigned CNT_W      = DEF_CNT_W,
  localparam int unsigned ID_W      = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1,
  localparam int unsigned EV_W      = $clog2(NUM_CACHES + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_CACHES-1:0]       miss_valid_i,
  input  logic [NUM_CACHES*SET_W-1:0] miss_set_i,
  input  logic [ID_W-1:0]             query_cache_i,
  input  logic [SET_W-1:0]            query_set_i,
  output logic                        role_o,
  output logic [1:0]                  class_o,
  output logic [NUM_CACHES-1:0]       policy_o
);
  // ev_*[c][p]: port p's miss set is a test set of cache c
  logic [NUM_CACHES-1:0] ev_spill [NUM_CACHES];
  logic [NUM_CACHES-1:0] ev_recv  [NUM_CACHES];
  logic [NUM_CACHES-1:0] q_spill, q_recv;
  logic [EV_W-1:0]       up_cnt [NUM_CACHES];
  logic [EV_W-1:0]       dn_cnt [NUM_CACHES];
  set_class_e            q_class;

  for (genvar c = 0; c < NUM_CACHES; c++) begin : g_cache
    for (genvar p = 0; p < NUM_CACHES; p++) begin : g_port
      sdm_classifier #(
        .SET_W(SET_W), .LO_W(LO_W), .NUM_CACHES(NUM_CACHES), .CACHE_ID(c)
      ) u_ev_cls (
        .set_i   (miss_set_i[p*SET_W +: SET_W]),
        .spill_o (ev_spill[c][p]),
        .recv_o  (ev_recv[c][p])
      );
    end

    sdm_classifier #(
      .SET_W(SET_W), .LO_W(LO_W), .NUM_CACHES(NUM_CACHES), .CACHE_ID(c)
    ) u_q_cls (
      .set_i   (query_set_i),
      .spill_o (q_spill[c]),
      .recv_o  (q_recv[c])
    );

    always_comb begin
      up_cnt[c] = '0;
      dn_cnt[c] = '0;
      for (int p = 0; p < NUM_CACHES; p++) begin
        up_cnt[c] = up_cnt[c] + EV_W'(miss_valid_i[p] & ev_recv[c][p]);
        dn_cnt[c] = dn_cnt[c] + EV_W'(miss_valid_i[p] & ev_spill[c][p]);
      end
    end

    psel_counter #(.CNT_W(CNT_W), .EV_W(EV_W)) u_psel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .up_i   (up_cnt[c]),
      .dn_i   (dn_cnt[c]),
      .msb_o  (policy_o[c])
    );
  end

  role_select #(.NUM_CACHES(NUM_CACHES), .ID_W(ID_W)) u_role (
    .query_id_i (query_cache_i),
    .spill_i    (q_spill),
    .recv_i     (q_recv),
    .policy_i   (policy_o),
    .role_o     (role_o),
    .class_o    (q_class)
  );

  assign class_o = q_class;

  a_r3_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({q_spill, q_recv}));
  a_r10_spill_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_o == CLS_SPILL) |-> role_o);
  a_r10_recv_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_o == CLS_RECV) |-> !role_o);
  a_r9_follow_policy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_o == CLS_FOLLOW) |-> (role_o == policy_o[query_cache_i]));
  a_r12_quiet_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i == '0) |=> $stable(policy_o));
endmodule

// File: tb/spill_receive_selector_test.sv
`timescale 1ns/1ps
module spill_receive_selector_test;
  localparam int NC = 4;
  localparam int SW = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NC-1:0]    mv;
  logic [NC*SW-1:0] ms;
  logic [1:0]       qc;
  logic [SW-1:0]    qs;
  logic             role;
  logic [1:0]       cls;
  logic [NC-1:0]    pol;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cnt [NC];
  int spill_n [NC];
  int recv_n [NC];
  int owners [1024];

  always #2 clk = ~clk;

  spill_receive_selector uut (
    .clk_i(clk), .rst_ni(rst_n), .miss_valid_i(mv), .miss_set_i(ms),
    .query_cache_i(qc), .query_set_i(qs),
    .role_o(role), .class_o(cls), .policy_o(pol)
  );

  // 0 follower, 1 always-spill, 2 always-receive
  function automatic int kind(int s, int c);
    int d;
    d = ((s % 32) - (s / 32) + 32) % 32;
    if (d == c) return 1;
    if (d == c + 4) return 2;
    return 0;
  endfunction

  function automatic int pick(int c, int k);
    int u, off;
    u = $urandom_range(0, 31);
    if (k == 1)      off = c;
    else if (k == 2) off = c + 4;
    else             off = $urandom_range(8, 31);
    return u * 32 + (u + off) % 32;
  endfunction

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) cnt[c] = 512;
    end else begin
      for (int c = 0; c < NC; c++) begin
        int d;
        d = 0;
        for (int p = 0; p < NC; p++) begin
          if (mv[p]) begin
            int k;
            k = kind(int'(ms[p*SW +: SW]), c);
            if (k == 2) d++;
            else if (k == 1) d--;
          end
        end
        cnt[c] = cnt[c] + d;
        if (cnt[c] > 1023) cnt[c] = 1023;
        if (cnt[c] < 0) cnt[c] = 0;
      end
    end
  end

  task automatic one_check(string req, bit ok, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare(string req);
    int ek, er, ep;
    ek = kind(int'(qs), int'(qc));
    ep = 0;
    for (int c = 0; c < NC; c++) if (cnt[c] >= 512) ep |= (1 << c);
    if (ek == 1)      er = 1;
    else if (ek == 2) er = 0;
    else              er = (cnt[qc] >= 512) ? 1 : 0;
    one_check({req, " class"}, int'(cls) == ek, int'(cls), ek);
    one_check({req, " role"}, int'(role) == er, int'(role), er);
    one_check({req, " policy"}, int'(pol) == ep, int'(pol), ep);
  endtask

  task automatic step(string req);
    @(negedge clk);
    compare(req);
  endtask

  task automatic rand_query();
    qc = 2'($urandom_range(0, 3));
    qs = SW'($urandom_range(0, 1023));
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at %0t", $time);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; mv = '0; ms = '0; qc = '0; qs = '0;
    repeat (3) @(negedge clk);
    // R8: reset state, every policy reads spill
    compare("R8 reset");
    rst_n = 1'b1;

    // R1 R2 R3 R10: full sweep, no misses
    for (int c = 0; c < NC; c++) begin spill_n[c] = 0; recv_n[c] = 0; end
    for (int s = 0; s < 1024; s++) owners[s] = 0;
    for (int c = 0; c < NC; c++) begin
      for (int s = 0; s < 1024; s++) begin
        qc = 2'(c); qs = SW'(s);
        step("R1 R2 R10 sweep");
        if (cls == 2'd1) spill_n[c]++;
        if (cls == 2'd2) recv_n[c]++;
        if (cls != 2'd0) owners[s]++;
      end
    end
    for (int c = 0; c < NC; c++) begin
      one_check("R1 spill group size", spill_n[c] == 32, spill_n[c], 32);
      one_check("R2 receive group size", recv_n[c] == 32, recv_n[c], 32);
    end
    begin
      int shared, total;
      shared = 0; total = 0;
      for (int s = 0; s < 1024; s++) begin
        if (owners[s] > 1) shared++;
        total += owners[s];
      end
      one_check("R3 sets in two groups", shared == 0, shared, 0);
      one_check("R3 dedicated total", total == 256, total, 256);
    end

    // R6: follower misses and invalid ports
    for (int i = 0; i < 200; i++) begin
      mv = 4'($urandom_range(0, 15));
      for (int p = 0; p < NC; p++) begin
        int cc;
        cc = $urandom_range(0, 3);
        ms[p*SW +: SW] = mv[p] ? SW'(pick(cc, 0)) : SW'(pick(cc, 1 + (p % 2)));
      end
      rand_query();
      step("R6 follower/invalid");
    end

    // R5 R7: drive cache 2 to the top and hold
    for (int i = 0; i < 200; i++) begin
      mv = '1;
      for (int p = 0; p < NC; p++) ms[p*SW +: SW] = SW'(pick(2, 2));
      qc = 2'd2; qs = SW'(pick(2, 0));
      step("R5 R7 saturate high");
    end
    // R4 R9 R12: single decrements until the learned bit flips
    for (int i = 0; i < 520; i++) begin
      mv = 4'b0001;
      ms[0 +: SW] = SW'(pick(2, 1));
      qc = 2'd2; qs = SW'(pick(2, 0));
      step("R4 R9 R12 descend");
    end
    // R7: drive to the floor and hold
    for (int i = 0; i < 300; i++) begin
      mv = '1;
      for (int p = 0; p < NC; p++) ms[p*SW +: SW] = SW'(pick(2, 1));
      rand_query();
      step("R7 saturate low");
    end

    // R11: opposing hits in one cycle cancel
    for (int i = 0; i < 100; i++) begin
      mv = 4'b0111;
      ms[0*SW +: SW] = SW'(pick(1, 2));
      ms[1*SW +: SW] = SW'(pick(1, 1));
      ms[2*SW +: SW] = SW'(pick(3, 2));
      qc = 2'd1; qs = SW'(pick(1, 0));
      step("R11 simultaneous");
    end

    // R4 R5 R11: random mix
    for (int i = 0; i < 3000; i++) begin
      mv = 4'($urandom_range(0, 15));
      for (int p = 0; p < NC; p++)
        ms[p*SW +: SW] = SW'(pick($urandom_range(0, 3), $urandom_range(0, 2)));
      rand_query();
      step("R4 R5 R11 random");
    end

    // R8: asynchronous reset mid-run
    @(negedge clk);
    mv = '0;
    rst_n = 1'b0;
    #1;
    compare("R8 async reset");
    one_check("R8 policy all spill", pol == 4'hF, int'(pol), 15);
    @(negedge clk);
    rst_n = 1'b1;
    step("R12 idle after reset");

    done = 1;
    finish_run();
  end
endmodule